// File: doc/BRIEF.md
# YCbCr Contrast, Brightness and Hue Stage

This block is a three-stage per-pixel pipeline placed in a display sprite path, ahead of a colour-space matrix. It accepts 10-bit pixels in YCbCr form, where luma is unsigned and both chroma components are already two's-complement signed. Luma is scaled by a contrast gain and then offset by a brightness value. Chroma is rotated and scaled by a sine/cosine pair. The usual job is to stretch limited-range video (luma 64..940, chroma ±448 in 10-bit codes) out to full range, so that the matrix that follows can assume full-range input. Pixels marked as RGB go through with their codes untouched.

Two 32-bit control words set up the stage. They are written through a plain one-cycle write strobe with a one-bit word select. The words have a single copy each, with no shadow, so a write acts on the next pixel the stage accepts, even part way through a frame. Pixels move in and out over valid/ready. A transfer happens on a rising edge when valid and ready are both high. The whole pipeline stalls as one unit: `in_ready` is high when the output register is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the output holds still and nothing moves inside the stage.

Top module: `ycc_tone_stage`

## Requirements
- R1: With `cfg_addr`=0, a write loads contrast from bits 26:18 (unsigned, 6 fractional bits, so 64 means 1.0) and brightness from bits 7:0 (signed, in 8-bit code units). All other bits of the word are ignored.
- R2: With `cfg_addr`=1, a write loads the sine term from bits 26:16 (signed, 7 fractional bits) and the cosine term from bits 9:0 (unsigned, 7 fractional bits, so 128 means 1.0). All other bits of the word are ignored.
- R3: Reset empties the pipeline (`out_valid`=0) and loads the identity settings: contrast 64, brightness 0, sine 0, cosine 128.
- R4: Output luma is computed as Y·contrast/64, rounded half-up, then brightness·4 is added, and the result is saturated to 0..1023. The contrast gain is applied before the brightness offset is added.
- R5: Output Cb is (cos·Cb + sin·Cr)/128 and output Cr is (cos·Cr − sin·Cb)/128. In each case the sum is rounded half-up and saturated to −512..511.
- R6: Under the identity settings, every YCbCr pixel comes out equal to its input.
- R7: A pixel whose `in_rgb` flag is 1 comes out with all three codes unchanged and `out_rgb`=1, whatever the control words hold.
- R8: A pixel uses the control words as they stand on the edge that accepts it. A write that lands while earlier pixels are still in the pipeline does not change those pixels.
- R9: A pixel accepted on edge k appears on the output after edge k+2. `in_ready` equals (not `out_valid`) or `out_ready`. The output holds stable while it is stalled, and pixels leave in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_addr | input | 1 | Selects the word: 0 = luma gain and offset, 1 = chroma sine and cosine |
| cfg_wdata | input | 32 | Control word write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Stage can accept a pixel |
| in_rgb | input | 1 | 1 = RGB pixel, passed through unchanged |
| in_y | input | 10 | Luma, unsigned |
| in_cb | input | 10 | Blue-difference chroma, two's complement |
| in_cr | input | 10 | Red-difference chroma, two's complement |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_rgb | output | 1 | Format flag travelling with the pixel |
| out_y | output | 10 | Adjusted luma |
| out_cb | output | 10 | Adjusted Cb, two's complement |
| out_cr | output | 10 | Adjusted Cr, two's complement |

## Verification
With `out_ready` held high, each pixel's result is due on the third rising edge counting the one that accepts it. The bench drives on falling edges, counts falling edges from acceptance until `out_valid` rises, checks that count is three, and only then compares the codes. A control write becomes visible one edge after its strobe, so every pixel that depends on a write is driven on a later edge. In the mid-stream and back-pressure tests, the bench works out the falling edge at which each queued pixel is at the output (including the empty slot between two spaced pixels) and samples exactly there.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

  // control word geometry (bit positions are decoded by software, keep them)
  localparam int CFG_W     = 32;
  localparam int CON_W     = 9;
  localparam int CON_FRAC  = 6;
  localparam int CON_LSB   = 18;
  localparam int BRI_W     = 8;
  localparam int BRI_LSB   = 0;
  localparam int BRI_SHL   = 2;   // 8-bit code units onto a 10-bit scale
  localparam int SIN_W     = 11;
  localparam int SIN_LSB   = 16;
  localparam int COS_W     = 10;
  localparam int COS_LSB   = 0;
  localparam int TRIG_FRAC = 7;

  typedef struct packed {
    logic [CON_W-1:0] contrast;
    logic [BRI_W-1:0] bright;
    logic [SIN_W-1:0] sin_t;
    logic [COS_W-1:0] cos_t;
  } tone_cfg_t;

  localparam tone_cfg_t CFG_IDENT = '{
    contrast: CON_W'(1 << CON_FRAC),
    bright:   '0,
    sin_t:    '0,
    cos_t:    COS_W'(1 << TRIG_FRAC)
  };

endpackage

// File: rtl/ycc_cfg_regs.sv
module ycc_cfg_regs
  import ycc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output tone_cfg_t        cfg_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= CFG_IDENT;
    end else if (cfg_wr) begin
      if (!cfg_addr) begin
        cfg_q.contrast <= cfg_wdata[CON_LSB +: CON_W];
        cfg_q.bright   <= cfg_wdata[BRI_LSB +: BRI_W];
      end else begin
        cfg_q.sin_t    <= cfg_wdata[SIN_LSB +: SIN_W];
        cfg_q.cos_t    <= cfg_wdata[COS_LSB +: COS_W];
      end
    end
  end

  // R1: a word-0 write lands in the luma fields, the chroma fields stay
  a_r1_word0_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_addr) |=> (cfg_q.contrast == $past(cfg_wdata[CON_LSB +: CON_W]))
                           && (cfg_q.bright == $past(cfg_wdata[BRI_LSB +: BRI_W]))
                           && $stable(cfg_q.sin_t) && $stable(cfg_q.cos_t));

  // R2: a word-1 write lands in the chroma fields, the luma fields stay
  a_r2_word1_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr) |=> (cfg_q.sin_t == $past(cfg_wdata[SIN_LSB +: SIN_W]))
                          && (cfg_q.cos_t == $past(cfg_wdata[COS_LSB +: COS_W]))
                          && $stable(cfg_q.contrast) && $stable(cfg_q.bright));

  // R8: settings only move on a write
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_q));

endmodule

// File: rtl/ycc_flow_ctrl.sv
module ycc_flow_ctrl #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic en,
  output logic in_ready,
  output logic out_valid
);

  logic [DEPTH-1:0] vld_q;

  assign out_valid = vld_q[DEPTH-1];
  assign en        = !vld_q[DEPTH-1] || out_ready;
  assign in_ready  = en;

  always_ff @(posedge clk) begin
    if (!rst_n)   vld_q <= '0;
    else if (en)  vld_q <= {vld_q[DEPTH-2:0], in_valid};
  end

  // R9: a valid output only goes away after downstream took it
  a_r9_drop_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  // R9: stalled means no new pixel may enter
  a_r9_no_entry_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(vld_q));

endmodule

// File: rtl/ycc_luma_lane.sv
module ycc_luma_lane
  import ycc_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic             clk,
  input  logic             en,
  input  logic [PIX_W-1:0] y_i,
  input  logic [CON_W-1:0] contrast_i,
  input  logic [BRI_W-1:0] bright_i,
  output logic [PIX_W-1:0] y_o
);

  localparam int PROD_W = PIX_W + CON_W;
  localparam int SUM_W  = PROD_W + 3;
  localparam logic [PROD_W:0]        HALF = (PROD_W+1)'(1) << (CON_FRAC - 1);
  localparam logic signed [SUM_W-1:0] YMAX = SUM_W'((1 << PIX_W) - 1);

  logic [PROD_W-1:0]        prod_q;
  logic [BRI_W-1:0]         bri_q;
  logic [PROD_W:0]          rnd;
  logic signed [SUM_W-1:0]  bri_ext;
  logic signed [SUM_W-1:0]  sum_d;
  logic signed [SUM_W-1:0]  sum_q;
  logic [PIX_W-1:0]         sat_d;

  // stage 2: round the gain product, then add the offset
  always_comb begin
    rnd     = {1'b0, prod_q} + HALF;
    bri_ext = SUM_W'($signed(bri_q)) <<< BRI_SHL;
    sum_d   = $signed(SUM_W'(rnd >> CON_FRAC)) + bri_ext;
  end

  // stage 3: clamp to the unsigned code range
  always_comb begin
    if (sum_q < 0)         sat_d = '0;
    else if (sum_q > YMAX) sat_d = '1;
    else                   sat_d = sum_q[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (en) begin
      prod_q <= PROD_W'(y_i) * PROD_W'(contrast_i);
      bri_q  <= bright_i;
      sum_q  <= sum_d;
      y_o    <= sat_d;
    end
  end

endmodule

// File: rtl/ycc_chroma_lane.sv
module ycc_chroma_lane
  import ycc_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic             clk,
  input  logic             en,
  input  logic [PIX_W-1:0] cb_i,
  input  logic [PIX_W-1:0] cr_i,
  input  logic [SIN_W-1:0] sin_i,
  input  logic [COS_W-1:0] cos_i,
  output logic [PIX_W-1:0] cb_o,
  output logic [PIX_W-1:0] cr_o
);

  localparam int PW_A  = COS_W + 1 + PIX_W;
  localparam int PW_B  = SIN_W + PIX_W;
  localparam int ACC_W = ((PW_A > PW_B) ? PW_A : PW_B) + 2;
  localparam int NCH   = 2;   // channel 0 = Cb, channel 1 = Cr
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (TRIG_FRAC - 1);
  localparam logic signed [ACC_W-1:0] CMAX = ACC_W'((1 << (PIX_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] CMIN = -CMAX - ACC_W'(1);

  function automatic logic [PIX_W-1:0] clamp_s(input logic signed [ACC_W-1:0] v);
    if (v > CMAX)      return {1'b0, {(PIX_W-1){1'b1}}};
    else if (v < CMIN) return {1'b1, {(PIX_W-1){1'b0}}};
    else               return v[PIX_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] cos_s, sin_s;
  logic signed [ACC_W-1:0] own_s  [NCH];   // component that the cosine scales
  logic signed [ACC_W-1:0] oth_s  [NCH];   // component that the sine mixes in
  logic [PIX_W-1:0]        res    [NCH];

  always_comb begin
    cos_s    = ACC_W'($signed({1'b0, cos_i}));
    sin_s    = ACC_W'($signed(sin_i));
    own_s[0] = ACC_W'($signed(cb_i));
    oth_s[0] = ACC_W'($signed(cr_i));
    own_s[1] = ACC_W'($signed(cr_i));
    oth_s[1] = -ACC_W'($signed(cb_i));
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [ACC_W-1:0] pc_q, ps_q, acc_q;
    logic signed [ACC_W-1:0] acc_d;
    logic [PIX_W-1:0]        out_q;

    assign acc_d = (pc_q + ps_q + HALF) >>> TRIG_FRAC;

    always_ff @(posedge clk) begin
      if (en) begin
        pc_q  <= cos_s * own_s[c];
        ps_q  <= sin_s * oth_s[c];
        acc_q <= acc_d;
        out_q <= clamp_s(acc_q);
      end
    end

    assign res[c] = out_q;
  end

  assign cb_o = res[0];
  assign cr_o = res[1];

endmodule

// File: rtl/ycc_tone_stage.sv
module ycc_tone_stage
  import ycc_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_rgb,
  input  logic [PIX_W-1:0] in_y,
  input  logic [PIX_W-1:0] in_cb,
  input  logic [PIX_W-1:0] in_cr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_rgb,
  output logic [PIX_W-1:0] out_y,
  output logic [PIX_W-1:0] out_cb,
  output logic [PIX_W-1:0] out_cr
);

  localparam int LAT   = 3;
  localparam int RAW_W = 1 + 3 * PIX_W;

  tone_cfg_t        cfg;
  logic             en;
  logic [PIX_W-1:0] adj_y, adj_cb, adj_cr;
  logic [RAW_W-1:0] raw_q [LAT];
  logic [RAW_W-1:0] raw_o;

  ycc_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg)
  );

  ycc_flow_ctrl #(.DEPTH(LAT)) u_flow (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .en        (en),
    .in_ready  (in_ready),
    .out_valid (out_valid)
  );

  ycc_luma_lane #(.PIX_W(PIX_W)) u_luma (
    .clk        (clk),
    .en         (en),
    .y_i        (in_y),
    .contrast_i (cfg.contrast),
    .bright_i   (cfg.bright),
    .y_o        (adj_y)
  );

  ycc_chroma_lane #(.PIX_W(PIX_W)) u_chroma (
    .clk   (clk),
    .en    (en),
    .cb_i  (in_cb),
    .cr_i  (in_cr),
    .sin_i (cfg.sin_t),
    .cos_i (cfg.cos_t),
    .cb_o  (adj_cb),
    .cr_o  (adj_cr)
  );

  // raw pixel and format flag ride alongside the arithmetic
  for (genvar g = 0; g < LAT; g++) begin : g_raw
    if (g == 0) begin : g_head
      always_ff @(posedge clk) if (en) raw_q[0] <= {in_rgb, in_y, in_cb, in_cr};
    end else begin : g_body
      always_ff @(posedge clk) if (en) raw_q[g] <= raw_q[g-1];
    end
  end

  assign raw_o   = raw_q[LAT-1];
  assign out_rgb = raw_o[RAW_W-1];
  assign out_y   = out_rgb ? raw_o[3*PIX_W-1 -: PIX_W] : adj_y;
  assign out_cb  = out_rgb ? raw_o[2*PIX_W-1 -: PIX_W] : adj_cb;
  assign out_cr  = out_rgb ? raw_o[PIX_W-1   -: PIX_W] : adj_cr;

  // R9: a stalled output does not change
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid
      && $stable(out_y) && $stable(out_cb) && $stable(out_cr) && $stable(out_rgb));

  // R9: ready back to the source follows the output slot
  a_r9_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

endmodule

// File: tb/sim_ycc_tone_stage.sv
module sim_ycc_tone_stage;

  localparam int PIX_W = 10;
  localparam int NV    = 12;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_wr;
  logic             cfg_addr;
  logic [31:0]      cfg_wdata;
  logic             in_valid;
  logic             in_ready;
  logic             in_rgb;
  logic [PIX_W-1:0] in_y, in_cb, in_cr;
  logic             out_valid;
  logic             out_ready;
  logic             out_rgb;
  logic [PIX_W-1:0] out_y, out_cb, out_cr;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5ns clk = ~clk;

  ycc_tone_stage #(.PIX_W(PIX_W)) u0 (.*);

  // vector table: control words, pixel in, pixel expected
  localparam logic [31:0] T_W0 [NV] = '{
    32'h0100_0000, 32'h012C_00ED, 32'h012C_00ED, 32'h012C_00ED,
    32'h012C_00ED, 32'h0100_0000, 32'h0100_0000, 32'hF903_FF00,
    32'h0100_007F, 32'h0000_0032, 32'h0180_0000, 32'h0100_0000};
  localparam logic [31:0] T_W1 [NV] = '{
    32'h0000_0080, 32'h0000_0092, 32'h0000_0092, 32'h0000_0092,
    32'h0000_0092, 32'h0080_0000, 32'h0780_0000, 32'hF800_FC80,
    32'h0000_0080, 32'h0000_0080, 32'h0000_0080, 32'h0000_0040};
  localparam bit T_RGB [NV] = '{0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0};
  localparam int T_Y   [NV] = '{500,   64, 940,  512, 100, 300,   0, 1023,  600, 900, 3, 10};
  localparam int T_CB  [NV] = '{-200, 448,   0, -512,   5, 100, 100,  511,    0,   1, 0,  3};
  localparam int T_CR  [NV] = '{300, -448,   0,  511,  -7, -50, -50, -512,    0,  -1, 0, -3};
  localparam int E_Y   [NV] = '{500,    0, 1023, 524, 100, 300,   0, 1023, 1023, 200, 5, 10};
  localparam int E_CB  [NV] = '{-200, 511,   0, -512,   5, -50,  50,  511,    0,   1, 0,  2};
  localparam int E_CR  [NV] = '{300, -511,   0,  511,  -7, -100, 100, -512,   0,  -1, 0, -1};
  string vtag [NV] = '{
    "R6 identity", "R4 expand low end", "R4 expand high end clamps",
    "R5 chroma clamps", "R7 rgb bypass", "R2 quarter turn",
    "R2 negative sine", "R1 reserved bits ignored", "R4 brightness clamps high",
    "R4 zero contrast then offset", "R4 luma half rounds up", "R5 chroma half rounds up"};

  task automatic fail_or_pass(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic check_px(input string tag, input int ey, input int ecb, input int ecr,
                          input bit ergb);
    int ay, acb, acr;
    ay  = int'(out_y);
    acb = int'($signed(out_cb));
    acr = int'($signed(out_cr));
    fail_or_pass(out_valid === 1'b1 && ay == ey && acb == ecb && acr == ecr && out_rgb === ergb,
      $sformatf("%s: got v=%0b y=%0d cb=%0d cr=%0d rgb=%0b, expected v=1 y=%0d cb=%0d cr=%0d rgb=%0b",
                tag, out_valid, ay, acb, acr, out_rgb, ey, ecb, ecr, ergb));
  endtask

  // called on a falling edge, returns on the next falling edge
  task automatic cfg_write(input bit a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic drive_px(input bit rgb, input int y, input int cb, input int cr);
    in_valid = 1'b1; in_rgb = rgb;
    in_y = y[PIX_W-1:0]; in_cb = cb[PIX_W-1:0]; in_cr = cr[PIX_W-1:0];
  endtask

  // one pixel through an empty pipeline with out_ready high
  task automatic run_one(input string tag, input bit rgb, input int y, input int cb, input int cr,
                         input int ey, input int ecb, input int ecr);
    int lat;
    drive_px(rgb, y, cb, cr);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    fail_or_pass(lat == 3, $sformatf("R9 latency (%s): got %0d edges, expected 3", tag, lat));
    check_px(tag, ey, ecb, ecr, rgb);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R9 watchdog: got no completion, expected completion within 20000 cycles");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = 1'b0; cfg_wdata = '0;
    in_valid = 1'b0; in_rgb = 1'b0; in_y = '0; in_cb = '0; in_cr = '0;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    fail_or_pass(out_valid === 1'b0, $sformatf("R3 in reset: got out_valid=%0b, expected 0", out_valid));
    rst_n = 1'b1;
    @(negedge clk);
    fail_or_pass(out_valid === 1'b0 && in_ready === 1'b1,
      $sformatf("R3 after reset: got out_valid=%0b in_ready=%0b, expected 0 and 1", out_valid, in_ready));

    // R3: reset settings are the identity
    run_one("R3 reset settings", 1'b0, 123, -45, 67, 123, -45, 67);

    for (int i = 0; i < NV; i++) begin
      cfg_write(1'b0, T_W0[i]);
      cfg_write(1'b1, T_W1[i]);
      run_one(vtag[i], T_RGB[i], T_Y[i], T_CB[i], T_CR[i], E_Y[i], E_CB[i], E_CR[i]);
    end

    // R8: a write while pixel A is in flight leaves A alone, hits B
    cfg_write(1'b0, 32'h0100_0000);
    cfg_write(1'b1, 32'h0000_0080);
    drive_px(1'b0, 200, 10, -10);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_wr = 1'b1; cfg_addr = 1'b0; cfg_wdata = 32'h0100_0019;   // brightness +25
    @(negedge clk);
    cfg_wr = 1'b0;
    drive_px(1'b0, 200, 10, -10);
    @(negedge clk);
    in_valid = 1'b0;
    check_px("R8 pixel in flight keeps old settings", 200, 10, -10, 1'b0);
    @(negedge clk);
    fail_or_pass(out_valid === 1'b0, $sformatf("R9 gap between pixels: got out_valid=%0b, expected 0", out_valid));
    @(negedge clk);
    check_px("R8 next pixel takes new settings", 300, 10, -10, 1'b0);

    // R9: back-pressure, hold and order
    cfg_write(1'b0, 32'h0100_0000);
    out_ready = 1'b0;
    drive_px(1'b0, 10, 1, 2);
    @(negedge clk);
    drive_px(1'b0, 20, 3, 4);
    @(negedge clk);
    drive_px(1'b0, 30, 5, 6);
    @(negedge clk);
    drive_px(1'b0, 40, 7, 8);
    fail_or_pass(in_ready === 1'b0, $sformatf("R9 full pipe: got in_ready=%0b, expected 0", in_ready));
    check_px("R9 first pixel at output", 10, 1, 2, 1'b0);
    repeat (3) @(negedge clk);
    check_px("R9 stalled output holds", 10, 1, 2, 1'b0);
    fail_or_pass(in_ready === 1'b0, $sformatf("R9 still stalled: got in_ready=%0b, expected 0", in_ready));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_px("R9 order second", 20, 3, 4, 1'b0);
    @(negedge clk);
    check_px("R9 order third", 30, 5, 6, 1'b0);
    @(negedge clk);
    check_px("R9 pixel offered during stall", 40, 7, 8, 1'b0);
    @(negedge clk);
    fail_or_pass(out_valid === 1'b0, $sformatf("R9 drained: got out_valid=%0b, expected 0", out_valid));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule